// File: doc/BRIEF.md
# Oscillator Enable and Power-Up Failure Supervisor

This block watches over the oscillator that drives a timekeeping circuit. It keeps a software-written stop control for that oscillator and drives the resulting enable. Each time the primary supply comes back, it checks that the oscillator is alive. A software write to the control register sets the stop bit. A stopped oscillator saves backup energy while the system sits in storage.

When the synchronized power-good signal rises and the oscillator is enabled, a window of `WIN_CYC` system clock cycles opens. At 50 MHz, the default of 250000 cycles gives 5 ms. A single edge on the synchronized oscillator activity input during the window proves the oscillator is alive. If no edge arrives, a sticky failure flag is raised. Software reads the flag and clears it by writing 0. If the supply drops again before the window closes, the check is abandoned.

After the stop bit is cleared, the oscillator may take up to two seconds to start. Logic that depends on the oscillator must allow for that delay.

Top module: `osc_supervisor`

## Requirements
- R1: After reset, `osc_en_o` is 1 (oscillator running) and `fail_o` is 0.
- R2: A write to address `CTRL_ADDR` (default 8) loads data bit `STOP_BIT` (default 7) into the stop control, active high: 1 stops the oscillator and 0 runs it. `osc_en_o` is the inverse of the stop control and shows the new value one clock after the write. Writes to any other address leave `osc_en_o` unchanged.
- R3: The check window opens when the two-flop-synchronized `pwr_good_i` rises while the stop control is 0, and it lasts `WIN_CYC` cycles. If no oscillator edge is seen during the window, `fail_o` becomes 1.
- R4: With the default `EDGE_MODE` of 0, one edge of `osc_act_i` in either direction is enough to end the window without raising the flag. The edge is detected after a two-flop synchronizer.
- R5: If the stop control is 1 when power-good rises, no window opens and `fail_o` is left unchanged, even if the oscillator is silent.
- R6: An oscillator edge that arrives after the window has expired does not prevent the flag from being set.
- R7: Once set, `fail_o` stays 1 regardless of oscillator activity or elapsed time, until a clearing write.
- R8: A write to address `FLAG_ADDR` (default 0) with data bit `FAIL_BIT` (default 4) equal to 0 clears `fail_o`. A write of 1 to that bit has no effect. A write to any other address also has no effect on the flag.
- R9: After the flag has been cleared, a later power-up check can set it again.
- R10: If power-good falls while the window is open, the check is abandoned and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Primary supply good, asynchronous |
| osc_act_i | input | 1 | Oscillator activity level, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| osc_en_o | output | 1 | Oscillator enable, 1 = running |
| fail_o | output | 1 | Sticky oscillator failure flag |

## Verification
The assertions check several rules on every cycle:
- The enable and the flag change only for the reasons allowed: a control write for the enable, and a clearing write or a timeout for the flag.
- A window opens only while the oscillator is enabled.
- A detected edge or a loss of power-good closes the window on the next cycle.

Only the bench scenarios can show the end-to-end timing: an early edge clears the check, a late edge does not, and a silent power-up raises the flag. They also show that the flag survives activity and writes of 1, and that it can be raised again after being cleared.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;

   typedef enum logic [0:0] {
      CHK_IDLE = 1'b0,
      CHK_RUN  = 1'b1
   } chk_state_e;

   localparam int unsigned EDGE_ANY  = 0;
   localparam int unsigned EDGE_RISE = 1;
   localparam int unsigned EDGE_FALL = 2;

endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("osc_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q[0] <= RST_VAL;
      end else begin
         chain_q[0] <= d_i;
      end
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            chain_q[i] <= RST_VAL;
         end else begin
            chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/osc_act_detect.sv
module osc_act_detect
   import osc_sup_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned EDGE_MODE   = EDGE_ANY
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic osc_i,
   output logic edge_o
);

   if (EDGE_MODE > EDGE_FALL) begin : g_bad_mode
      $error("osc_act_detect: unknown EDGE_MODE");
   end

   logic osc_sync;
   logic osc_prev_q;

   osc_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (osc_i),
      .q_o    (osc_sync)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         osc_prev_q <= 1'b0;
      end else begin
         osc_prev_q <= osc_sync;
      end
   end

   if (EDGE_MODE == EDGE_RISE) begin : g_rise
      assign edge_o = osc_sync & ~osc_prev_q;
   end else if (EDGE_MODE == EDGE_FALL) begin : g_fall
      assign edge_o = ~osc_sync & osc_prev_q;
   end else begin : g_any
      assign edge_o = osc_sync ^ osc_prev_q;
   end

endmodule

// File: rtl/osc_win_timer.sv
module osc_win_timer
   import osc_sup_pkg::*;
#(
   parameter int unsigned WIN_CYC = 250000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pg_sync_i,
   input  logic stop_i,
   input  logic act_edge_i,
   output logic active_o,
   output logic timeout_o
);

   localparam int unsigned CNT_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_CYC - 1);

   chk_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              pg_prev_q;
   logic              start;
   logic              at_last;

   assign start   = pg_sync_i & ~pg_prev_q & ~stop_i;
   assign at_last = (cnt_q == CNT_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pg_prev_q <= 1'b0;
      end else begin
         pg_prev_q <= pg_sync_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= CHK_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            CHK_IDLE: begin
               if (start) begin
                  state_q <= CHK_RUN;
                  cnt_q   <= '0;
               end
            end
            CHK_RUN: begin
               if (!pg_sync_i || act_edge_i || at_last) begin
                  state_q <= CHK_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= CHK_IDLE;
         endcase
      end
   end

   assign active_o  = (state_q == CHK_RUN);
   assign timeout_o = active_o & pg_sync_i & ~act_edge_i & at_last;

endmodule

// File: rtl/osc_ctrl_regs.sv
module osc_ctrl_regs #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CTRL_ADDR = 8,
   parameter int unsigned FLAG_ADDR = 0,
   parameter int unsigned STOP_BIT  = 7,
   parameter int unsigned FAIL_BIT  = 4,
   parameter logic        RST_STOP  = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              timeout_i,
   output logic              stop_o,
   output logic              fail_o
);

   logic ctrl_hit;
   logic flag_clr;

   assign ctrl_hit = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));
   assign flag_clr = wr_en_i && (wr_addr_i == ADDR_W'(FLAG_ADDR))
                     && !wr_data_i[FAIL_BIT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stop_o <= RST_STOP;
      end else if (ctrl_hit) begin
         stop_o <= wr_data_i[STOP_BIT];
      end
   end

   // a detection in the same cycle as a clearing write wins
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fail_o <= 1'b0;
      end else if (timeout_i) begin
         fail_o <= 1'b1;
      end else if (flag_clr) begin
         fail_o <= 1'b0;
      end
   end

endmodule

// File: rtl/osc_supervisor.sv
module osc_supervisor
   import osc_sup_pkg::*;
#(
   parameter int unsigned WIN_CYC     = 250000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned EDGE_MODE   = EDGE_ANY,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CTRL_ADDR   = 8,
   parameter int unsigned FLAG_ADDR   = 0,
   parameter int unsigned STOP_BIT    = 7,
   parameter int unsigned FAIL_BIT    = 4,
   parameter logic        RST_STOP    = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pwr_good_i,
   input  logic              osc_act_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              osc_en_o,
   output logic              fail_o
);

   if (WIN_CYC < 2) begin : g_bad_win
      $error("osc_supervisor: WIN_CYC must be at least 2");
   end
   if (STOP_BIT >= DATA_W || FAIL_BIT >= DATA_W) begin : g_bad_bits
      $error("osc_supervisor: field bit outside data width");
   end
   if (CTRL_ADDR >= (1 << ADDR_W) || FLAG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("osc_supervisor: register address outside address space");
   end
   if (CTRL_ADDR == FLAG_ADDR) begin : g_same_addr
      $error("osc_supervisor: control and flag registers must differ");
   end

   logic pg_sync;
   logic act_edge;
   logic win_active;
   logic win_timeout;
   logic stop_q;

   osc_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_pg_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pwr_good_i),
      .q_o    (pg_sync)
   );

   osc_act_detect #(
      .SYNC_STAGES (SYNC_STAGES),
      .EDGE_MODE   (EDGE_MODE)
   ) u_act (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .osc_i  (osc_act_i),
      .edge_o (act_edge)
   );

   osc_win_timer #(
      .WIN_CYC (WIN_CYC)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pg_sync_i  (pg_sync),
      .stop_i     (stop_q),
      .act_edge_i (act_edge),
      .active_o   (win_active),
      .timeout_o  (win_timeout)
   );

   osc_ctrl_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CTRL_ADDR (CTRL_ADDR),
      .FLAG_ADDR (FLAG_ADDR),
      .STOP_BIT  (STOP_BIT),
      .FAIL_BIT  (FAIL_BIT),
      .RST_STOP  (RST_STOP)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .timeout_i (win_timeout),
      .stop_o    (stop_q),
      .fail_o    (fail_o)
   );

   assign osc_en_o = ~stop_q;

endmodule

// File: rtl/osc_supervisor_chk.sv
module osc_supervisor_chk #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CTRL_ADDR = 8,
   parameter int unsigned FLAG_ADDR = 0,
   parameter int unsigned FAIL_BIT  = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic              osc_en_o,
   input logic              fail_o,
   input logic              pg_sync,
   input logic              act_edge,
   input logic              win_active
);

   assert_en_only_by_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(osc_en_o) |-> $past(wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR))));

   assert_fail_from_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fail_o) |-> $past(win_active));

   assert_edge_ends_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_active && pg_sync && act_edge) |=> (!win_active && !$rose(fail_o)));

   assert_no_window_when_stopped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(win_active) |-> $past(osc_en_o));

   assert_clear_only_by_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(fail_o) |-> $past(wr_en_i && (wr_addr_i == ADDR_W'(FLAG_ADDR))
                              && !wr_data_i[FAIL_BIT]));

   assert_power_loss_aborts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_active && !pg_sync) |=> (!win_active && !$rose(fail_o)));

endmodule

bind osc_supervisor osc_supervisor_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CTRL_ADDR (CTRL_ADDR),
   .FLAG_ADDR (FLAG_ADDR),
   .FAIL_BIT  (FAIL_BIT)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .wr_en_i    (wr_en_i),
   .wr_addr_i  (wr_addr_i),
   .wr_data_i  (wr_data_i),
   .osc_en_o   (osc_en_o),
   .fail_o     (fail_o),
   .pg_sync    (pg_sync),
   .act_edge   (act_edge),
   .win_active (win_active)
);

// File: tb/sim_osc_supervisor.sv
`timescale 1ns/1ps
module sim_osc_supervisor;

   localparam int WIN   = 24;
   localparam int SETTLE = WIN + 20;
   localparam int NVEC  = 6;
   // columns: stop bit before power-up, edge cycle after power-good (-1 none), expected flag
   localparam int VEC [NVEC][3] = '{
      '{0, -1,      1},   // R3 silent enabled oscillator
      '{0,  3,      0},   // R4 early edge
      '{0, -1,      1},   // R9 set again after clear
      '{1, -1,      0},   // R5 stopped, no check
      '{0,  WIN+8,  1},   // R6 edge after window
      '{0,  1,      0}    // R4 very early edge
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pg = 1'b0;
   logic       osc = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       osc_en;
   logic       fail;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   osc_supervisor #(.WIN_CYC(WIN)) u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .pwr_good_i (pg),
      .osc_act_i  (osc),
      .wr_en_i    (wr_en),
      .wr_addr_i  (wr_addr),
      .wr_data_i  (wr_data),
      .osc_en_o   (osc_en),
      .fail_o     (fail)
   );

   task automatic check(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %b expected %b", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic power_up(input int edge_at, input int len);
      pg = 1'b0;
      repeat (6) @(negedge clk);
      pg = 1'b1;
      for (int c = 0; c < len; c++) begin
         if (c == edge_at) osc = ~osc;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 enable after reset", osc_en, 1'b1);
      check("R1 flag after reset", fail, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 flag idle with power low", fail, 1'b0);

      for (int v = 0; v < NVEC; v++) begin
         wr(4'd8, VEC[v][0] ? 8'h80 : 8'h00);
         wr(4'd0, 8'h00);
         check("R8 flag cleared before run", fail, 1'b0);
         power_up(VEC[v][1], SETTLE);
         check("R3/R4/R5/R6/R9 vector flag", fail, VEC[v][2][0]);
         check("R2 vector enable", osc_en, !VEC[v][0][0]);
      end

      // R10: power lost inside the window
      wr(4'd8, 8'h00);
      wr(4'd0, 8'h00);
      power_up(-1, 8);
      pg = 1'b0;
      repeat (SETTLE) @(negedge clk);
      check("R10 aborted check leaves flag clear", fail, 1'b0);

      // R7 and R8: stickiness and ignored writes
      power_up(-1, SETTLE);
      check("R3 flag set before sticky test", fail, 1'b1);
      for (int k = 0; k < 6; k++) begin
         osc = ~osc;
         repeat (3) @(negedge clk);
      end
      repeat (WIN) @(negedge clk);
      check("R7 flag survives activity", fail, 1'b1);
      wr(4'd0, 8'h10);
      check("R8 writing one keeps flag", fail, 1'b1);
      wr(4'd3, 8'h00);
      check("R8 other address keeps flag", fail, 1'b1);
      wr(4'd0, 8'hEF);
      check("R8 clearing write", fail, 1'b0);

      // R2: stop control writes
      wr(4'd8, 8'h80);
      check("R2 stop bit stops oscillator", osc_en, 1'b0);
      wr(4'd9, 8'h00);
      check("R2 other address keeps enable", osc_en, 1'b0);
      wr(4'd8, 8'h7F);
      check("R2 clearing stop bit runs oscillator", osc_en, 1'b1);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired got hung expected finished");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule